// File: doc/BRIEF.md
# Linked-Load / Store-Conditional Link Unit

This block sits inside a level-one cache controller, between a processor core and the on-chip network, and turns the core's linked-load and store-conditional requests into network traffic. A linked load travels as an ordinary read. The returned data goes back to the core, and the block also keeps a copy in a local link register together with the address and the access width. The network never sees a linked-load command.

A store-conditional that matches the link register becomes a compare-and-swap packet. The packet carries the value saved at the linked load first, then the new store value, so the memory side can check whether its content has changed. A 32-bit access takes two flits and a 64-bit access takes four. The memory side answers with zero for success and non-zero for failure. The block can translate that answer into the convention the core expects.

A store-conditional that does not match the link register fails inside the block, and no packet is sent. Every store-conditional consumes the link. The core sees a busy flag while a store-conditional is out on the network. Every data path uses valid/ready: a transfer happens on a clock edge where both valid and ready are high. A sender holds valid and all payload stable until that edge.

Top module: `llsc_link_unit`

## Requirements
- R1: A linked load (core_req_sc=0) produces exactly one command flit: net_cmd_kind=0 (read), net_cmd_addr and net_cmd_wide equal to the request, net_cmd_last=1.
- R2: The read response is one flit for a 32-bit access and two flits (low half first) for a 64-bit access. The assembled value goes back on core_rsp_data, zero-extended for 32-bit, and is saved as the link value.
- R3: A store-conditional whose address and width both match a valid link produces a packet with net_cmd_kind=1. A 64-bit packet is four flits in this order: saved low, saved high, store low, store high. A 32-bit packet is two flits: saved low, then store low. net_cmd_last is high only on the final flit.
- R4: The status flit is zero for success and non-zero for failure. With INVERT_STATUS=1 the core receives 1 for success and 0 for failure. With INVERT_STATUS=0 it receives 0 for success and 1 for failure. The status is in bit 0 and all upper bits are zero.
- R5: A store-conditional with no valid link, a different address, or a different width fails without any command flit on the network and without raising core_busy. The core receives the failure code from R4.
- R6: After any store-conditional completes, whether it succeeded or failed locally or remotely, the link is invalid. An identical store-conditional that follows fails locally.
- R7: core_busy rises the cycle after a matching store-conditional is accepted. It stays high through the packet and the wait for the response, and falls in the cycle the result is offered to the core.
- R8: While net_cmd_valid is high and net_cmd_ready is low, the command flit, kind and address hold. While core_rsp_valid is high and core_rsp_ready is low, core_rsp_data holds.
- R9: Only one request is in flight at a time. core_req_ready is high only when the block is idle.
- R10: After reset the link is invalid, core_busy is low, no valid output is raised, and core_req_ready is high.
- R11: A newer linked load replaces the link. A store-conditional to the older address then fails locally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Block can accept a request |
| core_req_sc | input | 1 | 0 = linked load, 1 = store-conditional |
| core_req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| core_req_addr | input | AW | Access address |
| core_req_wdata | input | 2*FW | Store value (low FW bits used when narrow) |
| core_rsp_valid | output | 1 | Result to the core valid |
| core_rsp_ready | input | 1 | Core takes the result |
| core_rsp_data | output | 2*FW | Load data or status code |
| core_busy | output | 1 | Store-conditional in flight on the network |
| net_cmd_valid | output | 1 | Command flit valid |
| net_cmd_ready | input | 1 | Network takes the flit |
| net_cmd_kind | output | 1 | 0 = read, 1 = compare-and-swap |
| net_cmd_wide | output | 1 | Access width of the packet |
| net_cmd_addr | output | AW | Packet address |
| net_cmd_flit | output | FW | Command payload |
| net_cmd_last | output | 1 | Final flit of the packet |
| net_rsp_valid | input | 1 | Response flit valid |
| net_rsp_ready | output | 1 | Block takes a response flit |
| net_rsp_flit | input | FW | Response payload |

## Verification
A corrupted link register shows up at the first store-conditional after it. Either a packet appears where a local failure was due, or the reverse, or the leading flits carry the wrong saved value. All three can be seen within a few cycles of the request. A wrong sequencing state shows up as a wrong flit count, a missing or early last marker, or core_busy out of step with the packet. The bench catches each of these at the flit or the result it disturbs. An inverted status mapping appears in the very next result returned to the core.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_CMD = 3'd1,
    ST_RD_RSP = 3'd2,
    ST_SC_CMD = 3'd3,
    ST_SC_RSP = 3'd4,
    ST_RESP   = 3'd5
  } llsc_state_e;

  localparam logic KIND_READ = 1'b0;
  localparam logic KIND_CAS  = 1'b1;
endpackage

// File: rtl/llsc_link_reg.sv
module llsc_link_reg #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic [AW-1:0] load_addr,
  input  logic          load_wide,
  input  logic [DW-1:0] load_data,
  input  logic [AW-1:0] probe_addr,
  input  logic          probe_wide,
  output logic          hit,
  output logic [DW-1:0] data
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic          wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      wide_q  <= 1'b0;
      data    <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      addr_q  <= load_addr;
      wide_q  <= load_wide;
      data    <= load_data;
    end else if (clear) begin
      valid_q <= 1'b0;
    end
  end

  assign hit = valid_q && (addr_q == probe_addr) && (wide_q == probe_wide);
endmodule

// File: rtl/llsc_flit_pack.sv
module llsc_flit_pack #(
  parameter int FW = 32
) (
  input  logic [2*FW-1:0] link_data,
  input  logic [2*FW-1:0] store_data,
  input  logic            wide,
  input  logic [1:0]      idx,
  output logic [FW-1:0]   flit
);
  logic          take_store;
  logic          take_high;
  logic [2*FW-1:0] src;

  always_comb begin
    take_store = wide ? idx[1] : idx[0];
    take_high  = wide & idx[0];
    src        = take_store ? store_data : link_data;
    flit       = take_high ? src[2*FW-1:FW] : src[FW-1:0];
  end
endmodule

// File: rtl/llsc_status_map.sv
module llsc_status_map #(
  parameter bit INVERT_STATUS = 1'b1
) (
  input  logic net_failed,
  output logic core_code,
  output logic local_fail_code
);
  generate
    if (INVERT_STATUS) begin : g_invert
      assign core_code       = ~net_failed;
      assign local_fail_code = 1'b0;
    end else begin : g_pass
      assign core_code       = net_failed;
      assign local_fail_code = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/llsc_link_unit.sv
module llsc_link_unit
  import llsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int FW = 32,
  parameter bit INVERT_STATUS = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_req_valid,
  output logic            core_req_ready,
  input  logic            core_req_sc,
  input  logic            core_req_wide,
  input  logic [AW-1:0]   core_req_addr,
  input  logic [2*FW-1:0] core_req_wdata,
  output logic            core_rsp_valid,
  input  logic            core_rsp_ready,
  output logic [2*FW-1:0] core_rsp_data,
  output logic            core_busy,
  output logic            net_cmd_valid,
  input  logic            net_cmd_ready,
  output logic            net_cmd_kind,
  output logic            net_cmd_wide,
  output logic [AW-1:0]   net_cmd_addr,
  output logic [FW-1:0]   net_cmd_flit,
  output logic            net_cmd_last,
  input  logic            net_rsp_valid,
  output logic            net_rsp_ready,
  input  logic [FW-1:0]   net_rsp_flit
);
  localparam int DW = 2 * FW;

  llsc_state_e     state;
  logic            req_wide;
  logic [AW-1:0]   req_addr;
  logic [DW-1:0]   req_wdata;
  logic [1:0]      idx;
  logic [FW-1:0]   lo_hold;
  logic [DW-1:0]   rsp_data;

  logic            link_hit;
  logic [DW-1:0]   link_data;
  logic            link_load;
  logic            link_clear;
  logic [DW-1:0]   rd_value;
  logic [FW-1:0]   pack_flit;
  logic            status_code;
  logic            local_fail_code;
  logic [1:0]      last_idx;
  logic            accept;
  logic            rd_done;

  assign accept   = (state == ST_IDLE) && core_req_valid;
  assign last_idx = req_wide ? 2'd3 : 2'd1;
  assign rd_done  = (state == ST_RD_RSP) && net_rsp_valid && (!req_wide || idx == 2'd1);
  assign rd_value = req_wide ? {net_rsp_flit, lo_hold} : {{FW{1'b0}}, net_rsp_flit};

  assign link_load  = rd_done;
  assign link_clear = ((state == ST_SC_RSP) && net_rsp_valid) ||
                      (accept && core_req_sc && !link_hit);

  llsc_link_reg #(.AW(AW), .DW(DW)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (link_load),
    .clear      (link_clear),
    .load_addr  (req_addr),
    .load_wide  (req_wide),
    .load_data  (rd_value),
    .probe_addr (core_req_addr),
    .probe_wide (core_req_wide),
    .hit        (link_hit),
    .data       (link_data)
  );

  llsc_flit_pack #(.FW(FW)) u_pack (
    .link_data  (link_data),
    .store_data (req_wdata),
    .wide       (req_wide),
    .idx        (idx),
    .flit       (pack_flit)
  );

  llsc_status_map #(.INVERT_STATUS(INVERT_STATUS)) u_status (
    .net_failed      (net_rsp_flit != '0),
    .core_code       (status_code),
    .local_fail_code (local_fail_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_wide  <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      idx       <= '0;
      lo_hold   <= '0;
      rsp_data  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (core_req_valid) begin
          req_wide  <= core_req_wide;
          req_addr  <= core_req_addr;
          req_wdata <= core_req_wdata;
          idx       <= '0;
          if (!core_req_sc) begin
            state <= ST_RD_CMD;
          end else if (link_hit) begin
            state <= ST_SC_CMD;
          end else begin
            rsp_data <= {{(DW-1){1'b0}}, local_fail_code};
            state    <= ST_RESP;
          end
        end
        ST_RD_CMD: if (net_cmd_ready) begin
          state <= ST_RD_RSP;
          idx   <= '0;
        end
        ST_RD_RSP: if (net_rsp_valid) begin
          if (rd_done) begin
            rsp_data <= rd_value;
            state    <= ST_RESP;
          end else begin
            lo_hold <= net_rsp_flit;
            idx     <= 2'd1;
          end
        end
        ST_SC_CMD: if (net_cmd_ready) begin
          if (idx == last_idx) state <= ST_SC_RSP;
          else                 idx   <= idx + 2'd1;
        end
        ST_SC_RSP: if (net_rsp_valid) begin
          rsp_data <= {{(DW-1){1'b0}}, status_code};
          state    <= ST_RESP;
        end
        ST_RESP: if (core_rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    core_req_ready = (state == ST_IDLE);
    core_rsp_valid = (state == ST_RESP);
    core_rsp_data  = rsp_data;
    core_busy      = (state == ST_SC_CMD) || (state == ST_SC_RSP);
    net_cmd_valid  = (state == ST_RD_CMD) || (state == ST_SC_CMD);
    net_cmd_kind   = (state == ST_SC_CMD) ? KIND_CAS : KIND_READ;
    net_cmd_wide   = req_wide;
    net_cmd_addr   = req_addr;
    net_cmd_flit   = (state == ST_SC_CMD) ? pack_flit : '0;
    net_cmd_last   = (state == ST_RD_CMD) || (idx == last_idx);
    net_rsp_ready  = (state == ST_RD_RSP) || (state == ST_SC_RSP);
  end
endmodule

// File: rtl/llsc_link_unit_chk.sv
module llsc_link_unit_chk #(
  parameter int AW = 32,
  parameter int FW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_req_ready,
  input logic            core_rsp_valid,
  input logic            core_rsp_ready,
  input logic [2*FW-1:0] core_rsp_data,
  input logic            core_busy,
  input logic            net_cmd_valid,
  input logic            net_cmd_ready,
  input logic            net_cmd_kind,
  input logic [AW-1:0]   net_cmd_addr,
  input logic [FW-1:0]   net_cmd_flit,
  input logic            net_cmd_last,
  input logic            net_rsp_ready
);
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    net_cmd_valid && !net_cmd_ready |=> net_cmd_valid && $stable(net_cmd_flit)
      && $stable(net_cmd_addr) && $stable(net_cmd_kind));

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid && !core_rsp_ready |=> core_rsp_valid && $stable(core_rsp_data));

  p_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy |-> !core_req_ready);

  p_one_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid |-> !net_cmd_valid && !net_rsp_ready);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_busy) |-> core_rsp_valid);

  p_cas_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    net_cmd_valid && net_cmd_kind |-> core_busy);

  p_read_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    net_cmd_valid && !net_cmd_kind |-> net_cmd_last);
endmodule

bind llsc_link_unit llsc_link_unit_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_req_ready (core_req_ready),
  .core_rsp_valid (core_rsp_valid),
  .core_rsp_ready (core_rsp_ready),
  .core_rsp_data  (core_rsp_data),
  .core_busy      (core_busy),
  .net_cmd_valid  (net_cmd_valid),
  .net_cmd_ready  (net_cmd_ready),
  .net_cmd_kind   (net_cmd_kind),
  .net_cmd_addr   (net_cmd_addr),
  .net_cmd_flit   (net_cmd_flit),
  .net_cmd_last   (net_cmd_last),
  .net_rsp_ready  (net_rsp_ready)
);

// File: tb/llsc_link_unit_bench.sv
module llsc_link_unit_bench;
  localparam int AW = 32;
  localparam int FW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_req_valid = 1'b0, core_req_ready, core_req_sc = 1'b0, core_req_wide = 1'b0;
  logic [AW-1:0] core_req_addr = '0;
  logic [2*FW-1:0] core_req_wdata = '0;
  logic core_rsp_valid, core_rsp_ready = 1'b0;
  logic [2*FW-1:0] core_rsp_data;
  logic core_busy;
  logic net_cmd_valid, net_cmd_ready = 1'b0, net_cmd_kind, net_cmd_wide, net_cmd_last;
  logic [AW-1:0] net_cmd_addr;
  logic [FW-1:0] net_cmd_flit;
  logic net_rsp_valid = 1'b0, net_rsp_ready;
  logic [FW-1:0] net_rsp_flit = '0;

  always #10 clk = ~clk;

  llsc_link_unit #(.AW(AW), .FW(FW), .INVERT_STATUS(1'b1)) u_llsc_link_unit (.*);

  int checks = 0;
  int errors = 0;

  // bench model of the link
  bit mv = 1'b0;
  logic [AW-1:0] maddr = '0;
  bit mwide = 1'b0;
  logic [2*FW-1:0] mdata = '0;

  logic [FW-1:0] cf [4];
  logic ck [4];
  logic [AW-1:0] ca [4];
  logic cw [4];
  logic cl [4];
  logic busy_first;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sc_code(input bit net_fail);
    return {63'd0, ~net_fail};
  endfunction

  function automatic logic [FW-1:0] exp_flit(input bit wide, input int i,
                                             input logic [63:0] ld, input logic [63:0] sd);
    if (wide) begin
      case (i)
        0: return ld[31:0];
        1: return ld[63:32];
        2: return sd[31:0];
        default: return sd[63:32];
      endcase
    end
    return (i == 0) ? ld[31:0] : sd[31:0];
  endfunction

  task automatic send_req(input bit sc, input bit wide, input logic [AW-1:0] addr, input logic [63:0] wd);
    @(negedge clk);
    chk(core_req_ready == 1'b1, "R9", {63'd0, core_req_ready}, 64'd1);
    core_req_valid = 1'b1; core_req_sc = sc; core_req_wide = wide;
    core_req_addr = addr; core_req_wdata = wd;
    @(negedge clk);
    core_req_valid = 1'b0;
    chk(core_req_ready == 1'b0, "R9", {63'd0, core_req_ready}, 64'd0);
  endtask

  task automatic collect_cmd(output int n);
    logic [FW-1:0] hold;
    bit done;
    n = 0; done = 1'b0;
    while (!done) begin
      @(negedge clk);
      net_cmd_ready = 1'b0;
      if (net_cmd_valid) begin
        if ($urandom_range(0, 2) == 0) begin
          hold = net_cmd_flit;
          @(negedge clk);
          chk(net_cmd_valid && net_cmd_flit == hold, "R8", {32'd0, net_cmd_flit}, {32'd0, hold});
        end
        if (n == 0) busy_first = core_busy;
        if (n < 4) begin
          cf[n] = net_cmd_flit; ck[n] = net_cmd_kind; ca[n] = net_cmd_addr;
          cw[n] = net_cmd_wide; cl[n] = net_cmd_last;
        end
        n++;
        done = net_cmd_last || (n >= 6);
        net_cmd_ready = 1'b1;
      end
    end
    @(negedge clk);
    net_cmd_ready = 1'b0;
  endtask

  task automatic send_rsp(input logic [FW-1:0] f);
    @(negedge clk);
    net_rsp_valid = 1'b1; net_rsp_flit = f;
    while (!net_rsp_ready) @(negedge clk);
    @(negedge clk);
    net_rsp_valid = 1'b0;
  endtask

  task automatic get_core_rsp(output logic [63:0] d);
    logic [63:0] hold;
    while (!core_rsp_valid) @(negedge clk);
    chk(core_busy == 1'b0, "R7", {63'd0, core_busy}, 64'd0);
    if ($urandom_range(0, 1) == 0) begin
      hold = core_rsp_data;
      @(negedge clk);
      chk(core_rsp_valid && core_rsp_data == hold, "R8", core_rsp_data, hold);
    end
    d = core_rsp_data;
    core_rsp_ready = 1'b1;
    @(negedge clk);
    core_rsp_ready = 1'b0;
  endtask

  task automatic do_ll(input bit wide, input logic [AW-1:0] addr, input logic [31:0] lo, input logic [31:0] hi);
    int n;
    logic [63:0] d, e;
    send_req(1'b0, wide, addr, 64'd0);
    collect_cmd(n);
    chk(n == 1, "R1", 64'(n), 64'd1);
    chk(ck[0] == 1'b0 && cl[0] == 1'b1, "R1", {62'd0, ck[0], cl[0]}, 64'd1);
    chk(ca[0] == addr && cw[0] == wide, "R1", {32'd0, ca[0]}, {32'd0, addr});
    send_rsp(lo);
    if (wide) send_rsp(hi);
    get_core_rsp(d);
    e = wide ? {hi, lo} : {32'd0, lo};
    chk(d == e, "R2", d, e);
    mv = 1'b1; maddr = addr; mwide = wide; mdata = e;
  endtask

  task automatic do_sc(input bit wide, input logic [AW-1:0] addr, input logic [63:0] wd, input bit net_fail);
    int n;
    logic [63:0] d, e;
    bit hit;
    hit = mv && maddr == addr && mwide == wide;
    send_req(1'b1, wide, addr, wd);
    if (hit) begin
      collect_cmd(n);
      chk(busy_first == 1'b1, "R7", {63'd0, busy_first}, 64'd1);
      chk(n == (wide ? 4 : 2), "R3", 64'(n), wide ? 64'd4 : 64'd2);
      for (int i = 0; i < n && i < 4; i++) begin
        chk(cf[i] == exp_flit(wide, i, mdata, wd), "R3", {32'd0, cf[i]},
            {32'd0, exp_flit(wide, i, mdata, wd)});
        chk(ck[i] == 1'b1 && cl[i] == (i == n - 1), "R3", {62'd0, ck[i], cl[i]},
            {62'd0, 1'b1, i == n - 1});
      end
      send_rsp(net_fail ? 32'd1 : 32'd0);
      get_core_rsp(d);
      e = sc_code(net_fail);
      chk(d == e, "R4", d, e);
    end else begin
      for (int i = 0; i < 8 && !core_rsp_valid; i++) begin
        chk(net_cmd_valid == 1'b0 && core_busy == 1'b0, "R5",
            {62'd0, net_cmd_valid, core_busy}, 64'd0);
        @(negedge clk);
      end
      get_core_rsp(d);
      chk(d == 64'd0, "R5", d, 64'd0);
    end
    mv = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_req_ready && !core_rsp_valid && !net_cmd_valid && !core_busy && !net_rsp_ready,
        "R10", {59'd0, core_req_ready, core_rsp_valid, net_cmd_valid, core_busy, net_rsp_ready},
        64'h10);
    // R10: link empty after reset, so SC fails locally
    do_sc(1'b0, 32'h100, 64'h55, 1'b0);
    // R3 R4: narrow success
    do_ll(1'b0, 32'h100, 32'hA5A5_0001, 32'h0);
    do_sc(1'b0, 32'h100, 64'h1111_2222, 1'b0);
    // R6: link consumed, identical SC fails locally
    do_sc(1'b0, 32'h100, 64'h1111_2222, 1'b0);
    // R3 R4: wide, remote failure
    do_ll(1'b1, 32'h200, 32'hDEAD_0002, 32'hBEEF_0003);
    do_sc(1'b1, 32'h200, 64'h0123_4567_89AB_CDEF, 1'b1);
    do_sc(1'b1, 32'h200, 64'h5, 1'b0); // R6
    // R11: newer link replaces older
    do_ll(1'b0, 32'h300, 32'h3, 32'h0);
    do_ll(1'b0, 32'h304, 32'h4, 32'h0);
    do_sc(1'b0, 32'h300, 64'h9, 1'b0);
    // R5: width mismatch
    do_ll(1'b1, 32'h400, 32'h7, 32'h8);
    do_sc(1'b0, 32'h400, 64'h9, 1'b0);
    // R5: address mismatch
    do_ll(1'b0, 32'h500, 32'h7, 32'h0);
    do_sc(1'b0, 32'h504, 64'h9, 1'b0);
    // random mix
    for (int it = 0; it < 120; it++) begin
      bit wide;
      logic [AW-1:0] addr;
      wide = 1'($urandom_range(0, 1));
      addr = 32'h1000 + 32'(4 * $urandom_range(0, 2));
      if ($urandom_range(0, 2) == 0)
        do_sc(wide, addr, {$urandom, $urandom}, 1'($urandom_range(0, 1)));
      else if ($urandom_range(0, 1) == 0)
        do_ll(wide, addr, $urandom, $urandom);
      else begin
        do_ll(wide, addr, $urandom, $urandom);
        do_sc(wide, addr, {$urandom, $urandom}, 1'($urandom_range(0, 1)));
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule